// File: doc/BRIEF.md
# Audio Sample DMA Channel

This block is one DMA channel that carries audio frames between system memory and an audio sample stream. Each frame is a 16-bit signed stereo pair at 48 kHz, packed into one 32-bit word with the left sample in bits 31:16. A build-time parameter picks the direction. In playback the channel reads words from memory and hands them to the stream. In capture it takes words from the stream and writes them to memory.

Software programs three registers: an enable, a word-aligned current address and a byte count of what is still to be moved. The stream side reports how many frames it can take or supply right now. While the channel is enabled it runs bursts. Each burst is as long as the smaller of that level and the whole frames still owed. For every frame moved, the address goes up by four bytes and the remaining count goes down by four. When the count reaches zero on an enabled channel, a single-cycle interrupt marks the buffer as finished. Memory is reached through a one-word request/acknowledge master.

Top module: `aud_dma_chan`

## Requirements
- R1: After reset the control, address and remaining registers read zero, `stream_on` is low, and neither `mem_req` nor `done_irq` is asserted.
- R2: The register select codes are: 0 for control (bit 0 is the enable, other bits read zero), 1 for address (bits 1:0 always read zero), 2 for remaining (REM_W bits wide; upper write bits are dropped) and 3 (reads zero, writes ignored). `stream_on` follows the enable bit.
- R3: A burst starts only while the channel is enabled. Its length in frames is min(floor(remaining/4), smp_level), captured when the burst starts.
- R4: When that length is zero, the channel issues no memory request and no stream strobe, and the address and remaining registers keep their values. This covers a remaining count below 4 and a zero level.
- R5: Each completed frame adds 4 to the address and subtracts 4 from the remaining count.
- R6: `done_irq` is high for exactly one cycle. It fires in the cycle after the frame that brings the remaining count to zero, and only if the channel was enabled then.
- R7: In playback the word read from the current address comes out on `smp_out`. `smp_strobe` is high in the cycle the stream takes it, which needs `smp_ok` high.
- R8: In capture the channel takes `smp_in` in a cycle where `smp_ok` and `smp_strobe` are both high, and writes that word to the current address.
- R9: Before each frame the channel checks `smp_ok` and the enable. If either is low, the burst ends, and the registers account only for the frames actually moved.
- R10: Writes to the address or remaining register are ignored while a burst is in progress. Control writes always take effect.
- R11: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (capture) or read (playback) |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Word to be written (capture) |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read word, valid with the acknowledge |
| smp_level | input | LVL_W | Frames the stream can take or supply now |
| smp_ok | input | 1 | Stream can exchange one frame this cycle |
| smp_strobe | output | 1 | A frame is exchanged with the stream this cycle |
| smp_out | output | 32 | Frame to the stream (playback) |
| smp_in | input | 32 | Frame from the stream (capture) |
| stream_on | output | 1 | Stream active (enable bit) |
| done_irq | output | 1 | Buffer-finished pulse |

## Verification
Two situations are hard to reach from the ports: a stream that stops partway through a burst, and a software write that lands while a burst is running. The stream models in the bench stop raising `smp_ok` after a set number of frames, even while their reported level is still non-zero. This forces a burst to end early. For the busy-write case, the bench waits a fixed number of cycles after the enable so that the write is known to fall inside the burst. A sweep over remaining counts, including counts that are not multiples of four, and over stream levels exercises the min rule and the exact-zero interrupt in both directions.

// File: rtl/adma_pkg.sv
// Shared constants and types for the audio sample DMA channel.
package adma_pkg;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_LEFT = 2'd2;
    localparam int         FRAME_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLOT,
        ST_MEM,
        ST_PUSH
    } eng_e;
endpackage

// File: rtl/adma_regs.sv
// Register file of the channel: enable, current address and remaining bytes.
// Assumes the engine pulses frame_done once per moved frame and raises busy
// for the whole burst. Address and remaining writes are dropped while busy.
module adma_regs
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    input  logic              frame_done,
    output logic [31:0]       reg_rdata,
    output logic              en,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [REM_W-1:0]  left,
    output logic              done_irq
);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(FRAME_BYTES);
    localparam logic [REM_W-1:0]  LEFT_STEP = REM_W'(FRAME_BYTES);

    logic idle_wr;
    assign idle_wr = reg_we && !busy;

    // Enable bit: control writes are accepted at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                              en <= 1'b0;
        else if (reg_we && reg_sel == SEL_CTRL)  en <= reg_wdata[0];
    end

    // Address: advances per frame, otherwise loaded by software when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cur_addr <= '0;
        else if (frame_done)                       cur_addr <= cur_addr + ADDR_STEP;
        else if (idle_wr && reg_sel == SEL_ADDR)   cur_addr <= {reg_wdata[ADDR_W-1:2], 2'b00};
    end

    // Remaining bytes: counts down per frame, otherwise loaded when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                left <= '0;
        else if (frame_done)                       left <= left - LEFT_STEP;
        else if (idle_wr && reg_sel == SEL_LEFT)   left <= reg_wdata[REM_W-1:0];
    end

    // Completion pulse: the frame that empties the count on an enabled channel.
    always_ff @(posedge clk) begin
        if (!rst_n) done_irq <= 1'b0;
        else        done_irq <= frame_done && en && (left == LEFT_STEP);
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {31'd0, en};
            SEL_ADDR: reg_rdata = 32'(cur_addr);
            SEL_LEFT: reg_rdata = 32'(left);
            default:  reg_rdata = 32'd0;
        endcase
    end

    // R5
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (cur_addr == $past(cur_addr) + ADDR_STEP) && (left == $past(left) - LEFT_STEP));
    // R6
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (left == '0));
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && !frame_done) |=> ($stable(cur_addr) && $stable(left)));
endmodule

// File: rtl/adma_sizer.sv
// Burst length: whole frames still owed, capped by the stream level.
// Purely combinational; assumes REM_W >= 3.
module adma_sizer #(
    parameter int REM_W = 16,
    parameter int LVL_W = 8
) (
    input  logic [REM_W-1:0] left,
    input  logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] size
);
    localparam int CW = (REM_W - 2 > LVL_W) ? REM_W - 2 : LVL_W;

    logic [CW-1:0] owed_w;
    logic [CW-1:0] level_w;

    // Compare both counts at a common width and keep the smaller.
    always_comb begin
        owed_w  = CW'(left[REM_W-1:2]);
        level_w = CW'(level);
        size    = (owed_w < level_w) ? LVL_W'(owed_w) : level;
    end
endmodule

// File: rtl/adma_engine.sv
// Transfer engine: runs bursts one frame at a time over the memory master and
// the stream handshake. CAPTURE selects memory writes from the stream (1) or
// memory reads toward the stream (0). Assumes mem_ack is only raised while
// mem_req is high.
module adma_engine
    import adma_pkg::*;
#(
    parameter bit CAPTURE = 1'b0,
    parameter int ADDR_W  = 32,
    parameter int LVL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LVL_W-1:0]  size,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              smp_ok,
    input  logic [31:0]       smp_in,
    output logic              busy,
    output logic              frame_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              smp_strobe,
    output logic [31:0]       smp_out
);
    eng_e             state;
    logic [LVL_W-1:0] burst_left;
    logic [31:0]      word_q;
    logic             slot_go;
    logic             load_en;
    logic [31:0]      load_word;

    assign slot_go   = en && (burst_left != '0) && smp_ok;
    assign load_word = CAPTURE ? smp_in : mem_rdata;

    generate
        if (CAPTURE) begin : g_capture
            assign smp_strobe = (state == ST_SLOT) && slot_go;
            assign frame_done = (state == ST_MEM) && mem_ack;
            assign load_en    = smp_strobe;
        end else begin : g_playback
            assign smp_strobe = (state == ST_PUSH) && smp_ok;
            assign frame_done = smp_strobe;
            assign load_en    = (state == ST_MEM) && mem_ack;
        end
    endgenerate

    // Sequencer: start a burst, check the stream per frame, run the bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            burst_left <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (en && size != '0) begin
                    burst_left <= size;
                    state      <= ST_SLOT;
                end
                ST_SLOT: state <= slot_go ? ST_MEM : ST_IDLE;
                ST_MEM:  if (mem_ack) state <= CAPTURE ? ST_SLOT : ST_PUSH;
                ST_PUSH: if (smp_ok) state <= ST_SLOT;
                default: state <= ST_IDLE;
            endcase
            if (frame_done) burst_left <= burst_left - 1'b1;
        end
    end

    // Frame holding register: memory word (playback) or stream word (capture).
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (load_en) word_q <= load_word;
    end

    assign busy      = (state != ST_IDLE);
    assign mem_req   = (state == ST_MEM);
    assign mem_we    = CAPTURE && mem_req;
    assign mem_addr  = cur_addr;
    assign mem_wdata = CAPTURE ? word_q : 32'd0;
    assign smp_out   = CAPTURE ? 32'd0 : word_q;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
    // R4
    zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && size == '0) |=> (!mem_req && !smp_strobe && !frame_done));
    // R3
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (burst_left != '0));
    // R9
    stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT && !smp_ok) |=> (state == ST_IDLE));
endmodule

// File: rtl/aud_dma_chan.sv
// Audio sample DMA channel top: register file, burst sizer and engine.
// Assumes ADDR_W <= 32 and REM_W <= 32; one 32-bit stereo frame per word.
module aud_dma_chan #(
    parameter bit CAPTURE = 1'b0,
    parameter int ADDR_W  = 32,
    parameter int REM_W   = 16,
    parameter int LVL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic [LVL_W-1:0]  smp_level,
    input  logic              smp_ok,
    output logic              smp_strobe,
    output logic [31:0]       smp_out,
    input  logic [31:0]       smp_in,
    output logic              stream_on,
    output logic              done_irq
);
    logic              en;
    logic              busy;
    logic              frame_done;
    logic [ADDR_W-1:0] cur_addr;
    logic [REM_W-1:0]  left;
    logic [LVL_W-1:0]  size;

    adma_regs #(.ADDR_W(ADDR_W), .REM_W(REM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .frame_done(frame_done),
        .reg_rdata(reg_rdata), .en(en), .cur_addr(cur_addr), .left(left),
        .done_irq(done_irq)
    );

    adma_sizer #(.REM_W(REM_W), .LVL_W(LVL_W)) u_sizer (
        .left(left), .level(smp_level), .size(size)
    );

    adma_engine #(.CAPTURE(CAPTURE), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .size(size), .cur_addr(cur_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .smp_ok(smp_ok), .smp_in(smp_in),
        .busy(busy), .frame_done(frame_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .smp_strobe(smp_strobe),
        .smp_out(smp_out)
    );

    assign stream_on = en;
endmodule

// File: tb/sim_aud_dma_chan.sv
// Bench: a playback channel (u0) and a capture channel (u1) share one register bus.
module sim_aud_dma_chan;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        we = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] wdata = 32'd0;

    logic        req0, mwe0, ack0, ok0, stb0, on0, irq0;
    logic [31:0] addr0, wd0, rdat0, out0, rd0;
    logic        req1, mwe1, ack1, ok1, stb1, on1, irq1;
    logic [31:0] addr1, wd1, out1, rd1, in1;
    logic [7:0]  lv0, lv1;

    logic        clr = 1'b0;
    logic [7:0]  lvl_set = 8'd0;
    int          lim = 0;
    int          taken0, taken1, nirq0, nirq1;
    logic [31:0] got0 [64];
    logic [31:0] mem1 [64];

    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [31:0] pat0(int i);
        return {16'h1100 + 16'(i), 16'h2200 + 16'(i)};
    endfunction
    function automatic logic [31:0] pat1(int i);
        return {16'h3300 + 16'(i), 16'h4400 + 16'(i)};
    endfunction

    assign ok0 = (lv0 != 8'd0) && (taken0 < lim);
    assign ok1 = (lv1 != 8'd0) && (taken1 < lim);
    assign in1 = pat1(taken1);

    aud_dma_chan #(.CAPTURE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_sel(sel), .reg_wdata(wdata),
        .reg_rdata(rd0), .mem_req(req0), .mem_we(mwe0), .mem_addr(addr0),
        .mem_wdata(wd0), .mem_ack(ack0), .mem_rdata(rdat0), .smp_level(lv0),
        .smp_ok(ok0), .smp_strobe(stb0), .smp_out(out0), .smp_in(32'd0),
        .stream_on(on0), .done_irq(irq0)
    );

    aud_dma_chan #(.CAPTURE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_sel(sel), .reg_wdata(wdata),
        .reg_rdata(rd1), .mem_req(req1), .mem_we(mwe1), .mem_addr(addr1),
        .mem_wdata(wd1), .mem_ack(ack1), .mem_rdata(32'd0), .smp_level(lv1),
        .smp_ok(ok1), .smp_strobe(stb1), .smp_out(out1), .smp_in(in1),
        .stream_on(on1), .done_irq(irq1)
    );

    // Memory responders and stream models, both with a one-cycle acknowledge.
    always @(posedge clk) begin
        ack0  <= rst_n && req0 && !ack0;
        rdat0 <= pat0(int'(addr0[7:2]));
        ack1  <= rst_n && req1 && !ack1;
        if (req1 && !ack1 && mwe1) mem1[addr1[7:2]] <= wd1;
        if (clr) begin
            lv0 <= lvl_set; lv1 <= lvl_set;
            taken0 <= 0; taken1 <= 0; nirq0 <= 0; nirq1 <= 0;
            for (int i = 0; i < 64; i++) mem1[i] <= 32'd0;
        end else begin
            if (stb0) begin got0[taken0[5:0]] <= out0; taken0 <= taken0 + 1; lv0 <= lv0 - 8'd1; end
            if (stb1) begin taken1 <= taken1 + 1; lv1 <= lv1 - 8'd1; end
            if (irq0) nirq0 <= nirq0 + 1;
            if (irq1) nirq1 <= nirq1 + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); we = 1'b1; sel = s; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] a, output logic [31:0] b);
        sel = s; #1; a = rd0; b = rd1;
    endtask

    task automatic arm(input int level, input int limit);
        @(negedge clk); clr = 1'b1; lvl_set = 8'(level); lim = limit;
        @(negedge clk); clr = 1'b0;
    endtask

    // One programmed buffer: checks address, remaining, interrupt and data.
    task automatic run_case(input int sw, input int rb, input int level, input int limit, input bit en);
        int fr, mv, exp_irq;
        logic [31:0] a, b;
        wr(2'd0, 32'd0);
        repeat (4) @(negedge clk);
        arm(level, limit);
        wr(2'd1, 32'(sw * 4));
        wr(2'd2, 32'(rb));
        wr(2'd0, {31'd0, en});
        repeat (80) @(negedge clk);
        fr = rb / 4;
        mv = fr;
        if (level < mv) mv = level;
        if (limit < mv) mv = limit;
        if (!en) mv = 0;
        exp_irq = (mv > 0 && mv == fr && (rb % 4) == 0) ? 1 : 0;
        rd(2'd1, a, b);
        chk(a == 32'((sw + mv) * 4), $sformatf("R5 R3 R9 addr u0 rb=%0d lv=%0d", rb, level), a, 32'((sw + mv) * 4));
        chk(b == 32'((sw + mv) * 4), $sformatf("R5 R3 R9 addr u1 rb=%0d lv=%0d", rb, level), b, 32'((sw + mv) * 4));
        rd(2'd2, a, b);
        chk(a == 32'(rb - 4 * mv), $sformatf("R5 R4 left u0 rb=%0d lv=%0d", rb, level), a, 32'(rb - 4 * mv));
        chk(b == 32'(rb - 4 * mv), $sformatf("R5 R4 left u1 rb=%0d lv=%0d", rb, level), b, 32'(rb - 4 * mv));
        chk(nirq0 == exp_irq, "R6 irq count u0", 32'(nirq0), 32'(exp_irq));
        chk(nirq1 == exp_irq, "R6 irq count u1", 32'(nirq1), 32'(exp_irq));
        chk(taken0 == mv, "R7 R4 frames to stream u0", 32'(taken0), 32'(mv));
        chk(taken1 == mv, "R8 R4 frames from stream u1", 32'(taken1), 32'(mv));
        for (int k = 0; k < mv; k++) begin
            chk(got0[k] == pat0(sw + k), "R7 R11 playback word", got0[k], pat0(sw + k));
            chk(mem1[sw + k] == pat1(k), "R8 R11 capture word", mem1[sw + k], pat1(k));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        arm(0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 3; s++) begin
            rd(2'(s), a, b);
            chk(a == 32'd0 && b == 32'd0, "R1 register after reset", a | b, 32'd0);
        end
        chk(!on0 && !on1 && !req0 && !req1 && !irq0 && !irq1, "R1 outputs after reset",
            {26'd0, on0, on1, req0, req1, irq0, irq1}, 32'd0);

        // R2 register map
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd0, a, b);
        chk(a == 32'd0 && !on0, "R2 ctrl bit0 only", a, 32'd0);
        wr(2'd1, 32'h0000_1237);
        rd(2'd1, a, b);
        chk(a == 32'h0000_1234, "R2 address low bits", a, 32'h0000_1234);
        wr(2'd2, 32'h0001_2345);
        rd(2'd2, a, b);
        chk(a == 32'h0000_2345, "R2 remaining width", a, 32'h0000_2345);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, a, b);
        chk(a == 32'd0, "R2 unused select", a, 32'd0);
        wr(2'd0, 32'd1);
        rd(2'd0, a, b);
        chk(a == 32'd1 && on0 && on1, "R2 enable and stream_on", a, 32'd1);

        // R3 R4 R5 R6 sweep over remaining bytes and stream level
        foreach (int_rb_list[i]) begin
            for (int lv = 0; lv < 6; lv++) run_case(4, int_rb_list[i], lv, 99, 1'b1);
        end

        // R3 disabled channel moves nothing
        run_case(8, 8, 3, 99, 1'b0);

        // R9 stream stalls partway through a burst
        for (int lm = 1; lm < 4; lm++) run_case(40, 20, 5, lm, 1'b1);

        // R10 writes during a burst are ignored
        wr(2'd0, 32'd0);
        repeat (4) @(negedge clk);
        arm(4, 99);
        wr(2'd1, 32'd40);
        wr(2'd2, 32'd16);
        wr(2'd0, 32'd1);
        repeat (2) @(negedge clk);
        wr(2'd1, 32'h300);
        wr(2'd2, 32'h40);
        repeat (80) @(negedge clk);
        rd(2'd1, a, b);
        chk(a == 32'd56 && b == 32'd56, "R10 address after busy write", a, 32'd56);
        rd(2'd2, a, b);
        chk(a == 32'd0 && b == 32'd0, "R10 remaining after busy write", a | b, 32'd0);
        chk(nirq0 == 1 && nirq1 == 1, "R10 R6 interrupt after busy write", 32'(nirq0 + nirq1), 32'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    int int_rb_list [7] = '{0, 3, 4, 6, 8, 16, 20};
endmodule